// File: doc/BRIEF.md
# Key-Protected Two-Stage Watchdog Timer

This block is a memory-mapped watchdog for a system that must recover from a stalled processor. A down-counter runs off a timer tick enable and is refilled from a load register. The first time it runs out, the block only raises an interrupt, giving software a chance to service it. If the counter runs out again while that interrupt is still pending, the block requests a system reset, provided reset generation is enabled.

Software talks to the block over a simple single-cycle register port: an address, a write strobe, write data and combinational read data. Every configuration write is gated by a lock register. Writing one magic key to the lock register opens the other registers. Writing any other value to the lock register closes them again. Reads are never blocked. Software services the watchdog by writing any value to the interrupt-clear register. That write drops the pending interrupt and refills the counter in the same step.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the lock register reads 1 and the control register reads 0. The load register and the counter both read 0xFFFFFFFF. The irq output and the sys_rst_req output are both 0.
- R2: A write of 0x1ACCE551 to offset 0xC00 unlocks the block. A write of any other value to that offset locks it. The register at 0xC00 reads 0 when the block is unlocked and 1 when it is locked.
- R3: While the block is locked, a write to any offset other than 0xC00 changes no state. Reads still return the current values.
- R4: The control register at offset 0x008 has two bits. Bit 1 lets the counter run and lets the interrupt reach the irq output. Bit 0 allows reset generation. Bits 31:2 always read 0.
- R5: While control bit 1 is set, the counter decrements on every cycle on which tick_en is high. It holds its value otherwise. The step from 1 to 0 is an expiry. On the next tick after reaching 0, the counter refills from the load register.
- R6: A write to the load register at offset 0x000 refills the counter with the written value at the same clock edge, but only while control bit 1 is set. While bit 1 is clear, the write changes only the load register.
- R7: An expiry with no interrupt pending sets the pending flag. While the flag is set, the status register at offset 0x014 reads 1, and irq is high whenever control bit 1 is also set.
- R8: An unlocked write of any data to offset 0x00C clears the pending flag and refills the counter from the load register. The write takes precedence over an expiry in the same cycle.
- R9: An expiry while the interrupt is still pending and control bit 0 is set produces a sys_rst_req pulse that lasts exactly one cycle. The same clock edge clears control bit 1 and the pending flag.
- R10: An expiry while the interrupt is pending and control bit 0 is clear produces no reset. The pending flag stays set and the counter keeps running.
- R11: Offset 0x004 reads the live counter value. Offsets 0x004 and 0x014 are read-only. Any unmapped offset reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Counter tick enable, one decrement per high cycle |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Watchdog interrupt |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench targets the second expiry in two forms. With reset generation enabled, a design that pulses for more than one cycle, or that forgets to clear the enable bit, would show a repeated or stuck sys_rst_req. With reset generation disabled, a design that fires anyway, or that drops the pending flag, would be caught. The bench also lands an interrupt-clear write on the exact cycle of an expiry, where a wrong priority would leave the interrupt set. It writes the load register with the counter both stopped and running, where a wrong design would refill the counter when it should not, or fail to refill it when it should. Finally, it sends wrong-key and locked writes, where a leaky lock would let the control or load register change.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = 32;

  localparam logic [ADDR_W-1:0] OFF_LOAD  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_VALUE = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_ICLR  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_LOCK  = 12'hC00;

  localparam logic [DATA_W-1:0] OPEN_KEY = 32'h1ACCE551;

  // bit 1 = run, bit 0 = reset enable
  typedef struct packed {
    logic run;
    logic rst_en;
  } ctrl_t;
endpackage

// File: rtl/kwd_lock.sv
module kwd_lock
  import kwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked
);
  function automatic logic key_closes(input logic [DATA_W-1:0] v);
    return v != OPEN_KEY;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       locked <= 1'b1;
    else if (lock_wr) locked <= key_closes(wdata);
  end
endmodule

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rst_fire,
  output ctrl_t             ctrl,
  output logic [W-1:0]      load_q,
  output logic              load_wr,
  output logic              iclr_wr
);
  assign load_wr = wr_ok && (addr == OFF_LOAD);
  assign iclr_wr = wr_ok && (addr == OFF_ICLR);

  logic ctrl_wr;
  assign ctrl_wr = wr_ok && (addr == OFF_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '1;
    end else if (load_wr) begin
      load_q <= wdata[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl.run    <= wdata[1];
        ctrl.rst_en <= wdata[0];
      end
      if (rst_fire) ctrl.run <= 1'b0;
    end
  end
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         refill,
  input  logic [W-1:0] refill_val,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         expire
);
  function automatic logic [W-1:0] step_down(input logic [W-1:0] cur,
                                             input logic [W-1:0] ld);
    return (cur == '0) ? ld : cur - W'(1);
  endfunction

  function automatic logic reaches_zero(input logic [W-1:0] cur);
    return cur == W'(1);
  endfunction

  logic stepping;
  assign stepping = run && tick;
  assign expire   = stepping && !refill && reaches_zero(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '1;
    else if (refill)   cnt <= refill_val;
    else if (stepping) cnt <= step_down(cnt, load_val);
  end
endmodule

// File: rtl/kwd_stage.sv
module kwd_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic iclr,
  input  logic rst_en,
  output logic pend,
  output logic rst_fire,
  output logic rst_req
);
  assign rst_fire = expire && pend && rst_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= rst_fire;
      if (iclr || rst_fire) pend <= 1'b0;
      else if (expire)      pend <= 1'b1;
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sys_rst_req
);
  localparam int unsigned W = CNT_W;

  logic         locked_w;
  logic         wr_ok_w;
  ctrl_t        ctrl_w;
  logic [W-1:0] load_w;
  logic         load_wr_w;
  logic         iclr_w;
  logic         refill_w;
  logic [W-1:0] refill_val_w;
  logic [W-1:0] cnt_w;
  logic         expire_w;
  logic         pend_w;
  logic         fire_w;
  logic         run_w;
  logic         rsten_w;

  assign wr_ok_w = bus_we && !locked_w;
  assign run_w   = ctrl_w.run;
  assign rsten_w = ctrl_w.rst_en;

  kwd_lock u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_wr (bus_we && (bus_addr == OFF_LOCK)),
    .wdata   (bus_wdata),
    .locked  (locked_w)
  );

  kwd_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ok    (wr_ok_w),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rst_fire (fire_w),
    .ctrl     (ctrl_w),
    .load_q   (load_w),
    .load_wr  (load_wr_w),
    .iclr_wr  (iclr_w)
  );

  assign refill_w     = iclr_w || (load_wr_w && run_w);
  assign refill_val_w = iclr_w ? load_w : bus_wdata[W-1:0];

  kwd_counter #(.W(W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_w),
    .tick       (tick_en),
    .refill     (refill_w),
    .refill_val (refill_val_w),
    .load_val   (load_w),
    .cnt        (cnt_w),
    .expire     (expire_w)
  );

  kwd_stage u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire   (expire_w),
    .iclr     (iclr_w),
    .rst_en   (rsten_w),
    .pend     (pend_w),
    .rst_fire (fire_w),
    .rst_req  (sys_rst_req)
  );

  assign irq = pend_w && run_w;

  always_comb begin
    case (bus_addr)
      OFF_LOAD:  bus_rdata = DATA_W'(load_w);
      OFF_VALUE: bus_rdata = DATA_W'(cnt_w);
      OFF_CTRL:  bus_rdata = DATA_W'(ctrl_w);
      OFF_STAT:  bus_rdata = DATA_W'(pend_w);
      OFF_LOCK:  bus_rdata = DATA_W'(locked_w);
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
  import kwd_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              sys_rst_req,
  input logic              lock_q,
  input logic              run_w,
  input logic              rsten_w,
  input logic              pend_w,
  input logic              expire_w,
  input logic              refill_w,
  input logic [W-1:0]      cnt_w,
  input logic [W-1:0]      load_w
);
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req); // R9
  AST_RST_AFTER_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> ($past(pend_w) && $past(rsten_w))); // R9
  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> (!run_w && !pend_w)); // R9
  AST_LOCKED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && bus_we && bus_addr == OFF_LOAD) |=> $stable(load_w)); // R3
  AST_FIRST_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && !pend_w) |=> pend_w); // R7
  AST_NO_RST_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && !rsten_w) |=> !sys_rst_req); // R10
  AST_CTRL_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFF_CTRL) |-> (bus_rdata[DATA_W-1:2] == '0)); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && tick_en && !refill_w && cnt_w != '0) |=> (cnt_w == W'($past(cnt_w) - W'(1)))); // R5
endmodule

bind keyed_watchdog kwd_checker #(.W(kwd_pkg::CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .bus_rdata   (bus_rdata),
  .sys_rst_req (sys_rst_req),
  .lock_q      (locked_w),
  .run_w       (run_w),
  .rsten_w     (rsten_w),
  .pend_w      (pend_w),
  .expire_w    (expire_w),
  .refill_w    (refill_w),
  .cnt_w       (cnt_w),
  .load_w      (load_w)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
  import kwd_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick_en = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq;
  logic              sys_rst_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  bit        m_lock, m_run, m_rsten, m_pend, m_rst;
  bit [31:0] m_load, m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_watchdog u_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sys_rst_req(sys_rst_req)
  );

  function automatic bit [31:0] ref_read(input bit [11:0] a);
    if (a == OFF_LOAD)  return m_load;
    if (a == OFF_VALUE) return m_cnt;
    if (a == OFF_CTRL)  return {30'd0, m_run, m_rsten};
    if (a == OFF_STAT)  return {31'd0, m_pend};
    if (a == OFF_LOCK)  return {31'd0, m_lock};
    return 32'd0;
  endfunction

  task automatic chk32(input bit [31:0] act, input bit [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ref_step(input bit we, input bit [11:0] a, input bit [31:0] d, input bit tk);
    bit open_wr, is_clr, refill, expd, fire;
    bit [31:0] nxt;
    open_wr = we && !m_lock;
    is_clr  = open_wr && (a == OFF_ICLR);
    refill  = is_clr || (open_wr && a == OFF_LOAD && m_run);
    expd    = !refill && m_run && tk && (m_cnt == 32'd1);
    fire    = expd && m_pend && m_rsten;
    nxt = m_cnt;
    if (refill) nxt = is_clr ? m_load : d;
    else if (m_run && tk) nxt = (m_cnt == 0) ? m_load : m_cnt - 32'd1;
    m_cnt = nxt;
    if (is_clr || fire) m_pend = 1'b0;
    else if (expd) m_pend = 1'b1;
    if (open_wr && a == OFF_CTRL) begin m_run = d[1]; m_rsten = d[0]; end
    if (fire) m_run = 1'b0;
    if (open_wr && a == OFF_LOAD) m_load = d;
    if (we && a == OFF_LOCK) m_lock = (d != OPEN_KEY);
    m_rst = fire;
  endtask

  // one cycle: drive, check read before edge, update model, check outputs after
  task automatic cyc(input bit we, input bit [11:0] a, input bit [31:0] d, input bit tk,
                     input string tag);
    bus_we = we; bus_addr = a; bus_wdata = d; tick_en = tk;
    #1;
    chk32(bus_rdata, ref_read(a), tag);
    @(posedge clk);
    ref_step(we, a, d, tk);
    @(negedge clk);
    chk32({31'd0, irq}, {31'd0, m_pend && m_run}, "R7");
    chk32({31'd0, sys_rst_req}, {31'd0, m_rst}, "R9");
  endtask

  task automatic rd(input bit [11:0] a, input bit [31:0] lit, input string tag);
    bus_we = 0; bus_addr = a; tick_en = 0;
    #1;
    chk32(bus_rdata, lit, tag);
    cyc(0, a, 0, 0, tag);
  endtask

  task automatic wr(input bit [11:0] a, input bit [31:0] d);
    cyc(1, a, d, 0, "R11");
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, OFF_VALUE, 0, 1, "R5");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit [11:0] amap [7];
    m_lock = 1; m_run = 0; m_rsten = 0; m_pend = 0; m_rst = 0;
    m_load = 32'hFFFF_FFFF; m_cnt = 32'hFFFF_FFFF;
    amap = '{OFF_LOAD, OFF_VALUE, OFF_CTRL, OFF_ICLR, OFF_STAT, OFF_LOCK, 12'h010};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(OFF_LOCK, 1, "R1");
    rd(OFF_CTRL, 0, "R1");
    rd(OFF_LOAD, 32'hFFFF_FFFF, "R1");
    rd(OFF_VALUE, 32'hFFFF_FFFF, "R1");
    chk32({30'd0, irq, sys_rst_req}, 0, "R1");
    // R3 locked writes ignored
    wr(OFF_LOAD, 5);
    wr(OFF_CTRL, 3);
    rd(OFF_LOAD, 32'hFFFF_FFFF, "R3");
    rd(OFF_CTRL, 0, "R3");
    // R2 key handling
    wr(OFF_LOCK, 32'h1ACCE550);
    rd(OFF_LOCK, 1, "R2");
    wr(OFF_LOCK, OPEN_KEY);
    rd(OFF_LOCK, 0, "R2");
    // R4 reserved bits
    wr(OFF_CTRL, 32'hFFFF_FFFF);
    rd(OFF_CTRL, 3, "R4");
    wr(OFF_CTRL, 0);
    // R6 load while stopped
    wr(OFF_LOAD, 5);
    rd(OFF_VALUE, 32'hFFFF_FFFF, "R6");
    // R8 clear refills
    wr(OFF_ICLR, 32'h0);
    rd(OFF_VALUE, 5, "R8");
    // R5 counting and holding
    wr(OFF_CTRL, 2);
    ticks(3);
    rd(OFF_VALUE, 2, "R5");
    rd(OFF_VALUE, 2, "R5");
    // R6 load while running
    wr(OFF_LOAD, 9);
    rd(OFF_VALUE, 9, "R6");
    wr(OFF_LOAD, 3);
    ticks(3);
    rd(OFF_VALUE, 0, "R5");
    rd(OFF_STAT, 1, "R7");
    chk32({31'd0, irq}, 1, "R7");
    ticks(1);
    rd(OFF_VALUE, 3, "R5");
    // R10 second expiry, reset disabled
    ticks(3);
    chk32({31'd0, sys_rst_req}, 0, "R10");
    rd(OFF_STAT, 1, "R10");
    rd(OFF_CTRL, 2, "R10");
    wr(OFF_ICLR, 32'h1234);
    rd(OFF_STAT, 0, "R8");
    rd(OFF_VALUE, 3, "R8");
    // R9 second expiry with reset enabled
    wr(OFF_CTRL, 3);
    ticks(3);
    rd(OFF_STAT, 1, "R9");
    ticks(4);
    chk32({31'd0, sys_rst_req}, 1, "R9");
    rd(OFF_CTRL, 1, "R9");
    chk32({31'd0, sys_rst_req}, 0, "R9");
    rd(OFF_STAT, 0, "R9");
    // R8 clear on the cycle of an expiry
    wr(OFF_ICLR, 0);
    wr(OFF_CTRL, 2);
    ticks(2);
    rd(OFF_VALUE, 1, "R8");
    cyc(1, OFF_ICLR, 0, 1, "R8");
    rd(OFF_STAT, 0, "R8");
    rd(OFF_VALUE, 3, "R8");
    // R11 read-only and unmapped
    wr(OFF_VALUE, 32'hAAAA);
    wr(OFF_STAT, 1);
    wr(12'h010, 32'h55);
    rd(12'h010, 0, "R11");
    rd(OFF_VALUE, 3, "R11");
    rd(OFF_STAT, 0, "R11");
    // R3 relock, clear ignored
    wr(OFF_LOCK, 0);
    ticks(3);
    wr(OFF_ICLR, 0);
    rd(OFF_STAT, 1, "R3");
    // random phase
    wr(OFF_LOCK, OPEN_KEY);
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      bit [11:0] a;
      bit we, tk;
      bit [31:0] d;
      a  = amap[$urandom_range(0, 6)];
      we = ($urandom_range(0, 3) == 0);
      tk = ($urandom_range(0, 9) < 7);
      d  = $urandom;
      if (a == OFF_LOAD) d = $urandom_range(1, 12);
      if (a == OFF_LOCK) d = ($urandom_range(0, 7) != 0) ? OPEN_KEY : d;
      if (a == OFF_CTRL) d = ($urandom_range(0, 3) != 0) ? {30'd0, 1'b1, d[0]} : d;
      cyc(we, a, d, tk, "R11");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule